// File: doc/BRIEF.md
# Multi-Cycle Word Processor Core with Hardwired Sequencer

This block is a small 32-bit processor core that executes one instruction over several clock cycles. A hardwired state machine steps each instruction through the phases it needs: fetch, decode with register read, execute, memory access and write-back. Internal holding registers carry values from one phase to the next. These are the instruction word, two operand latches, a memory data latch and an ALU result latch. A 32-entry register file with a hard-wired zero entry holds the program state.

Instructions and data share one word-wide memory port. The port has a read strobe, a write strobe and a ready return. Every state that touches memory holds its request until ready is seen, so a cache or a slow memory can sit behind the port. The core supports register add, signed set-less-than, add-immediate, word load, word store, branch-if-equal and jump. The all-ones primary opcode stops the core. After that it makes no further memory requests and raises a done flag. A free-running cycle count stops at the same moment, so software or a bench can read the cost of a program.

Top module: `mc_core`

## Requirements
- R1: Synchronous active-high reset sets the program counter to 0 and clears the cycle count and done. The first cycle after reset is a read of address 0.
- R2: A fetch asserts the read strobe with the program counter on the address lines. On ready it latches the word and adds 4 to the program counter. The read and write strobes are never high together.
- R3: Opcode 0 with funct 0x20 writes rs+rt to rd. Opcode 0 with funct 0x2A writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise.
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate (bits 15:0) to rt (bits 20:16).
- R5: Opcode 0x23 loads the word at rs+sign-extended immediate into rt. Opcode 0x2B writes rt to that address, with rt on the write-data lines.
- R6: Opcode 0x04 sets the program counter to (address of branch + 4) + (sign-extended immediate × 4) only when rs equals rt. Otherwise execution falls through.
- R7: Opcode 0x02 sets the program counter to bits 31:28 of (address of jump + 4), followed by the 26-bit target field, followed by two zero bits.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: While a strobe is high and ready is low, the address, write data and strobes hold steady and the core does not advance. The cost of each instruction is fixed apart from wait cycles: 4 cycles for add, slt, addi and store; 5 for load; 3 for branch and jump; 2 for the halt word. Each memory access adds one cycle per wait cycle.
- R10: Opcode 0x3F puts the core in a halted state. It raises done and issues no further reads or writes until the next reset.
- R11: The cycle count rises by one on every clock while the core is not halted and holds its value once halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address of the current memory request |
| mem_wdata | output | 32 | Store data |
| mem_rd | output | 1 | Read request (fetch or load) |
| mem_wr | output | 1 | Write request (store) |
| mem_rdata | input | 32 | Read data returned by memory |
| mem_ready | input | 1 | Memory has completed the current request this cycle |
| done | output | 1 | Core has reached the halt opcode |
| cycle_count | output | 32 | Clock cycles spent since reset while running |

## Verification
Two things can fall in the same cycle: the opening of a memory request and its completion. This happens when memory answers with ready in the first cycle of a fetch, load or store. The same program is run behind memory that answers at once and behind memory that inserts one or two wait cycles per access. At zero latency every request completes in the cycle that raised it, and the later states must pick up the latched word without losing a cycle. With wait cycles, the request must be held unchanged. Both cases are judged by the stream of stores, which must match the expected address and data in order, and by the final cycle count, which must equal the fixed instruction cost plus the latency times the number of accesses.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MADDR, S_MREAD, S_MLOAD, S_MSTORE,
    S_REX, S_RWB, S_IEX, S_IWB, S_BR, S_JMP, S_HALT
  } state_t;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_SLT
  } alu_op_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_STOP  = 6'h3F;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SLT   = 6'h2A;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_t      op,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    unique case (op)
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (diff == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       mem_ready,
  output state_t     state
);
  state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_FETCH:  if (mem_ready) nxt = S_DECODE;
      S_DECODE: begin
        unique case (opcode)
          OP_RTYPE: nxt = (funct == FN_ADD || funct == FN_SLT) ? S_REX : S_FETCH;
          OP_ADDI:  nxt = S_IEX;
          OP_LOAD,
          OP_STORE: nxt = S_MADDR;
          OP_BEQ:   nxt = S_BR;
          OP_JMP:   nxt = S_JMP;
          OP_STOP:  nxt = S_HALT;
          default:  nxt = S_FETCH;
        endcase
      end
      S_MADDR:  nxt = (opcode == OP_LOAD) ? S_MREAD : S_MSTORE;
      S_MREAD:  if (mem_ready) nxt = S_MLOAD;
      S_MSTORE: if (mem_ready) nxt = S_FETCH;
      S_REX:    nxt = S_RWB;
      S_IEX:    nxt = S_IWB;
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= nxt;
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             mem_rd,
  output logic             mem_wr,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ready,
  output logic             done,
  output logic [CNT_W-1:0] cycle_count
);
  localparam int RAW = $clog2(NREGS);

  state_t          state;
  logic [XLEN-1:0] pc, ir, a_q, b_q, mdr, alu_out;
  logic [XLEN-1:0] simm, alu_a, alu_b, alu_y, rd1, rd2, wd;
  logic            alu_zero, we;
  logic [RAW-1:0]  wa;
  alu_op_t         alu_op;

  assign simm = {{(XLEN-16){ir[15]}}, ir[15:0]};

  mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(ir[31:26]), .funct(ir[5:0]),
    .mem_ready(mem_ready), .state(state)
  );

  always_comb begin
    alu_a  = a_q;
    alu_b  = b_q;
    alu_op = ALU_ADD;
    unique case (state)
      S_DECODE: begin alu_a = pc; alu_b = simm << 2; end
      S_MADDR, S_IEX: alu_b = simm;
      S_REX: alu_op = (ir[5:0] == FN_SLT) ? ALU_SLT : ALU_ADD;
      S_BR:  alu_op = ALU_SUB;
      default: ;
    endcase
  end

  mc_alu #(.W(XLEN)) u_alu (
    .a(alu_a), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero)
  );

  assign we = (state == S_RWB) || (state == S_IWB) || (state == S_MLOAD);
  assign wa = (state == S_RWB) ? ir[11+RAW-1:11] : ir[16+RAW-1:16];
  assign wd = (state == S_MLOAD) ? mdr : alu_out;

  mc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk(clk), .ra1(ir[21+RAW-1:21]), .ra2(ir[16+RAW-1:16]),
    .rd1(rd1), .rd2(rd2), .we(we), .wa(wa), .wd(wd)
  );

  assign mem_rd    = (state == S_FETCH) || (state == S_MREAD);
  assign mem_wr    = (state == S_MSTORE);
  assign mem_addr  = (state == S_FETCH) ? pc : alu_out;
  assign mem_wdata = b_q;
  assign done      = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      ir          <= '0;
      a_q         <= '0;
      b_q         <= '0;
      mdr         <= '0;
      alu_out     <= '0;
      cycle_count <= '0;
    end else begin
      if (state != S_HALT) cycle_count <= cycle_count + 1'b1;
      unique case (state)
        S_FETCH: if (mem_ready) begin
          ir <= mem_rdata;
          pc <= pc + XLEN'(4);
        end
        S_DECODE: begin
          a_q     <= rd1;
          b_q     <= rd2;
          alu_out <= alu_y;
        end
        S_MADDR, S_REX, S_IEX: alu_out <= alu_y;
        S_MREAD: if (mem_ready) mdr <= mem_rdata;
        S_BR:    if (alu_zero) pc <= alu_out;
        S_JMP:   pc <= {pc[XLEN-1:28], ir[25:0], 2'b00};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int XLEN  = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  mem_addr,
  input logic [XLEN-1:0]  mem_wdata,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             mem_ready,
  input logic             done,
  input logic [CNT_W-1:0] cycle_count
);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)));

  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !mem_rd && !mem_wr));

  a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
    !done |=> (cycle_count == $past(cycle_count) + 1'b1));

  a_r11_count_frozen: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(cycle_count));
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
  .done(done), .cycle_count(cycle_count)
);

// File: tb/mc_core_test.sv
module mc_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, mem_ready;
  logic        done;
  logic [31:0] cycle_count;

  int n_checks = 0;
  int n_fail   = 0;
  int lat      = 0;
  int wcnt     = 0;
  int ticks    = 0;
  logic [31:0] mem [256];

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } store_t;
  store_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .cycle_count(cycle_count)
  );

  // memory model: read only, fixed wait count per access
  assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (rst || mem_ready) wcnt <= 0;
    else if (mem_rd || mem_wr) wcnt <= wcnt + 1;
  end

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // scoreboard monitor: every completed store is compared in order
  always @(negedge clk) begin
    if (!rst && mem_wr && mem_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R6 R7 unexpected store addr", mem_addr, 32'hx);
      end else begin
        store_t e;
        e = sb.pop_front();
        check(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
        check(mem_wdata == e.data, {e.tag, " data"}, mem_wdata, e.data);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 50000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 50000", ticks);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic push(input logic [31:0] a, input logic [31:0] d, input string t);
    store_t e;
    e.addr = a; e.data = d; e.tag = t;
    sb.push_back(e);
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h08, 0, 1, 5);           // addi r1 = 5
    mem[1]  = enc_i(6'h08, 0, 2, -3);          // addi r2 = -3
    mem[2]  = enc_r(1, 2, 3, 6'h20);           // add r3 = 2
    mem[3]  = enc_i(6'h2B, 0, 3, 'h100);
    mem[4]  = enc_r(2, 1, 4, 6'h2A);           // slt r4 = (-3<5)
    mem[5]  = enc_i(6'h2B, 0, 4, 'h104);
    mem[6]  = enc_r(1, 2, 5, 6'h2A);           // slt r5 = (5<-3)
    mem[7]  = enc_i(6'h2B, 0, 5, 'h108);
    mem[8]  = enc_i(6'h23, 0, 6, 'h200);       // lw r6
    mem[9]  = enc_i(6'h08, 6, 7, 1);           // addi r7 = r6+1
    mem[10] = enc_i(6'h2B, 0, 7, 'h10C);
    mem[11] = enc_i(6'h04, 1, 2, 2);           // beq not taken
    mem[12] = enc_i(6'h2B, 0, 1, 'h110);
    mem[13] = enc_i(6'h04, 3, 3, 1);           // beq taken -> 0x3c
    mem[14] = enc_i(6'h2B, 0, 0, 'h114);       // skipped
    mem[15] = {6'h02, 26'h12};                 // j 0x48
    mem[16] = enc_i(6'h2B, 0, 0, 'h118);       // skipped
    mem[17] = enc_i(6'h2B, 0, 0, 'h11C);       // skipped
    mem[18] = enc_i(6'h2B, 0, 2, 'h120);
    mem[19] = enc_r(1, 1, 0, 6'h20);           // add r0 = 10 (ignored)
    mem[20] = enc_i(6'h2B, 0, 0, 'h124);
    mem[21] = 32'hFC00_0000;                   // halt
    mem[22] = enc_i(6'h2B, 0, 1, 'h128);       // never reached
    mem[8'h80] = 32'h1234_5678;
  endtask

  task automatic run_prog(input int l);
    int wait_cyc;
    lat = l;
    load_program();
    sb.delete();
    push(32'h100, 32'd2,          "R3 add");
    push(32'h104, 32'd1,          "R3 slt signed true");
    push(32'h108, 32'd0,          "R3 slt false");
    push(32'h10C, 32'h1234_5679,  "R5 load then R4 addi");
    push(32'h110, 32'd5,          "R6 branch not taken");
    push(32'h120, 32'hFFFF_FFFD,  "R7 jump target, R4 negative imm");
    push(32'h124, 32'd0,          "R8 zero register");
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(mem_rd == 1'b1 && mem_wr == 1'b0, "R1 first cycle reads", {30'd0, mem_rd, mem_wr}, 32'd2);
    check(mem_addr == 32'h0, "R1 reset address", mem_addr, 32'h0);
    check(cycle_count == 32'h0, "R1 reset count", cycle_count, 32'h0);
    check(done == 1'b0, "R1 done clear", {31'd0, done}, 32'd0);
    wait_cyc = 0;
    while (!done && wait_cyc < 3000) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(done == 1'b1, "R10 done raised", {31'd0, done}, 32'd1);
    check(cycle_count == 32'(72 + 27 * l), "R9 R11 total cycles",
          cycle_count, 32'(72 + 27 * l));
    check(sb.size() == 0, "R6 R7 stores missing", 32'(sb.size()), 32'd0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!mem_rd && !mem_wr && done, "R10 halted quiet",
            {29'd0, mem_rd, mem_wr, done}, 32'd1);
    end
    check(cycle_count == 32'(72 + 27 * l), "R11 count frozen",
          cycle_count, 32'(72 + 27 * l));
  endtask

  initial begin
    run_prog(0);
    run_prog(2);
    run_prog(1);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule